// File: doc/BRIEF.md
# Dual-Event Input Capture Unit

This block watches the bidirectional event pin of a general-purpose timer while that pin is configured as an input. It resynchronises the asynchronous pin level to the timer clock, detects the edges chosen by a two-bit mode field, and on each qualifying edge copies the live counter value into one of two capture slots. The slots fill in order. After both are full, further edges are dropped until software clears the capture status.

The capture flag rises after the first capture or after the second, depending on a one-bit selection. Software then reads the slots and writes the clear strobe, which rearms the unit so that the next edge lands in the first slot again. Enabling capture after it was off also rearms the unit. The counter itself lives outside the block and arrives as an input word.

Top module: `evt_capture_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, both slots read zero, `cap_irq` is 0 and `cap_held` is 0.
- R2: `cap_mode` selects the qualifying edges of the synchronised pin: 0 none, 1 rising, 2 falling, 3 both. A pin change that is set up before clock edge E1 is seen after E2. The slot then holds the `count_value` that is present just before E3.
- R3: While `pin_is_input` is 0, no edge changes either slot or `cap_held`.
- R4: The first qualifying edge after the unit is armed writes `cap_first` and sets `cap_held` to 1. The next one writes `cap_second` and sets `cap_held` to 2.
- R5: While `cap_held` is 2, qualifying edges leave both slots and `cap_held` unchanged.
- R6: With `cap_on_second` = 0, `cap_irq` goes to 1 on the cycle that the first slot is written.
- R7: With `cap_on_second` = 1, the first capture leaves `cap_irq` at 0, and the cycle that writes the second slot sets it to 1.
- R8: A cycle with `clr_status` = 1 sets `cap_held` to 0 and `cap_irq` to 0 at the next edge. An edge detected in that same cycle is not captured. The slots keep their values.
- R9: When `cap_mode` changes from 0 to a nonzero value, `cap_held` goes to 0 at the next edge. An edge detected in that cycle is not captured.
- R10: With `cap_mode` = 0, no pin activity changes either slot or `cap_held`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pin | input | 1 | Asynchronous event pin level |
| pin_is_input | input | 1 | 1 when the pin is configured as an input |
| cap_mode | input | 2 | Edge selection: 0 none, 1 rising, 2 falling, 3 both |
| cap_on_second | input | 1 | 1: flag after the second capture; 0: after the first |
| clr_status | input | 1 | One-cycle strobe: software writes 1 to the capture status |
| count_value | input | CW | Live counter value |
| cap_first | output | CW | First capture slot |
| cap_second | output | CW | Second capture slot |
| cap_irq | output | 1 | Sticky capture status / interrupt |
| cap_held | output | 2 | Number of captures held (0 to 2) |

## Verification
The assertions assume that `clr_status` is a level the timer clock samples, and that `cap_mode`, `pin_is_input` and `count_value` are stable at each rising edge. Only `evt_pin` may change at any time. The bench drives every input on the falling clock edge and toggles the pin only there, so the synchroniser never sees a metastable value in the model. Mode and direction changes are kept rare in the random phase, so that long runs of captures, saturation and clears all occur between them.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    CAP_OFF  = 2'd0,
    CAP_RISE = 2'd1,
    CAP_FALL = 2'd2,
    CAP_BOTH = 2'd3
  } cap_mode_e;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cap_edge.sv
module cap_edge
  import cap_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl,
  input  cap_mode_e mode,
  output logic      hit
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  always_comb begin
    unique case (mode)
      CAP_RISE: hit = lvl & ~prev;
      CAP_FALL: hit = ~lvl & prev;
      CAP_BOTH: hit = lvl ^ prev;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_store.sv
module cap_store
  import cap_pkg::*;
#(
  parameter int CW    = 32,
  parameter int NSLOT = 2,
  localparam int NW   = $clog2(NSLOT + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hit,
  input  logic                dir_in,
  input  cap_mode_e           mode,
  input  logic                second,
  input  logic                clr,
  input  logic [CW-1:0]       counter,
  output logic [NSLOT*CW-1:0] slots,
  output logic                flag,
  output logic [NW-1:0]       held
);
  cap_mode_e mode_q;
  logic      arm;
  logic      take;
  logic [NW-1:0] flag_at;

  assign arm     = (mode_q == CAP_OFF) && (mode != CAP_OFF);
  assign take    = hit && dir_in && !clr && !arm && (held < NW'(NSLOT));
  assign flag_at = second ? NW'(NSLOT - 1) : NW'(0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= CAP_OFF;
      held   <= '0;
      flag   <= 1'b0;
    end else begin
      mode_q <= mode;
      if (clr || arm)  held <= '0;
      else if (take)   held <= held + NW'(1);
      if (clr)                          flag <= 1'b0;
      else if (take && held == flag_at) flag <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst)                          slots[i*CW +: CW] <= '0;
        else if (take && held == NW'(i))  slots[i*CW +: CW] <= counter;
      end
    end
  endgenerate

  AST_HELD_MAX: assert property (@(posedge clk) disable iff (rst)
    held <= NW'(NSLOT)); // R4
  AST_NO_CAPT_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    !dir_in |=> $stable(slots)); // R3
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (held == NW'(NSLOT)) && !clr && !arm |=> $stable(slots) && (held == NW'(NSLOT))); // R5
  AST_CLR_REARM: assert property (@(posedge clk) disable iff (rst)
    clr |=> (held == '0) && !flag && $stable(slots)); // R8
  AST_ARM_REARM: assert property (@(posedge clk) disable iff (rst)
    arm && !clr |=> (held == '0)); // R9
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode == CAP_OFF) |=> $stable(slots)); // R10
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> (held != '0)); // R6
endmodule

// File: rtl/evt_capture_unit.sv
module evt_capture_unit
  import cap_pkg::*;
#(
  parameter int CW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_pin,
  input  logic          pin_is_input,
  input  logic [1:0]    cap_mode,
  input  logic          cap_on_second,
  input  logic          clr_status,
  input  logic [CW-1:0] count_value,
  output logic [CW-1:0] cap_first,
  output logic [CW-1:0] cap_second,
  output logic          cap_irq,
  output logic [1:0]    cap_held
);
  localparam int NSLOT = 2;

  cap_mode_e            mode_e;
  logic                 pin_s;
  logic                 hit;
  logic [NSLOT*CW-1:0]  slots;

  assign mode_e = cap_mode_e'(cap_mode);

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(evt_pin), .q(pin_s)
  );

  cap_edge u_edge (
    .clk(clk), .rst(rst), .lvl(pin_s), .mode(mode_e), .hit(hit)
  );

  cap_store #(.CW(CW), .NSLOT(NSLOT)) u_store (
    .clk(clk), .rst(rst), .hit(hit), .dir_in(pin_is_input), .mode(mode_e),
    .second(cap_on_second), .clr(clr_status), .counter(count_value),
    .slots(slots), .flag(cap_irq), .held(cap_held)
  );

  assign cap_first  = slots[0 +: CW];
  assign cap_second = slots[CW +: CW];
endmodule

// File: tb/tb_evt_capture_unit.sv
module tb_evt_capture_unit;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_pin = 1'b0;
  logic pin_is_input = 1'b0;
  logic [1:0] cap_mode = 2'd0;
  logic cap_on_second = 1'b0;
  logic clr_status = 1'b0;
  logic [CW-1:0] count_value = '0;
  logic [CW-1:0] cap_first, cap_second;
  logic cap_irq;
  logic [1:0] cap_held;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  evt_capture_unit #(.CW(CW)) dut (
    .clk(clk), .rst(rst), .evt_pin(evt_pin), .pin_is_input(pin_is_input),
    .cap_mode(cap_mode), .cap_on_second(cap_on_second), .clr_status(clr_status),
    .count_value(count_value), .cap_first(cap_first), .cap_second(cap_second),
    .cap_irq(cap_irq), .cap_held(cap_held)
  );

  // Reference model built from the requirements
  logic m_s1, m_s2, m_prev;
  logic [1:0] m_modeq, m_held;
  logic m_flag;
  logic [CW-1:0] m_a, m_b;

  function automatic bit qualifies(input logic [1:0] md, input logic cur, input logic prv);
    case (md)
      2'd1: return cur & ~prv;
      2'd2: return ~cur & prv;
      2'd3: return cur ^ prv;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit arm, take;
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_modeq <= 0;
      m_held <= 0; m_flag <= 0; m_a <= '0; m_b <= '0;
    end else begin
      arm  = (m_modeq == 2'd0) && (cap_mode != 2'd0);
      take = qualifies(cap_mode, m_s2, m_prev) && pin_is_input && !clr_status
             && !arm && (m_held < 2);
      m_s1 <= evt_pin; m_s2 <= m_s1; m_prev <= m_s2; m_modeq <= cap_mode;
      if (clr_status || arm) m_held <= 0;
      else if (take) m_held <= m_held + 2'd1;
      if (take && m_held == 0) m_a <= count_value;
      if (take && m_held == 1) m_b <= count_value;
      if (clr_status) m_flag <= 0;
      else if (take && (m_held == (cap_on_second ? 2'd1 : 2'd0))) m_flag <= 1;
    end
  end

  task automatic compare();
    checks++;
    if ({cap_first, cap_second, cap_irq, cap_held} !== {m_a, m_b, m_flag, m_held}) begin
      errors++;
      $display("FAIL %s: got first=%h second=%h irq=%0d held=%0d expected first=%h second=%h irq=%0d held=%0d",
               tag, cap_first, cap_second, cap_irq, cap_held, m_a, m_b, m_flag, m_held);
    end
  endtask

  // one cycle: sample at falling edge, then present a new counter value
  task automatic tick();
    @(negedge clk);
    compare();
    count_value = $urandom;
    clr_status = 1'b0;
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic toggle(input int gap);
    evt_pin = ~evt_pin;
    hold(gap);
  endtask

  task automatic clear();
    clr_status = 1'b1;
    hold(1);
  endtask

  task automatic expect_direct(input string t, input logic [CW-1:0] got, input logic [CW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] lat_val;
    void'($urandom(32'd1234));
    // R1: reset state
    tag = "R1";
    hold(3);
    rst = 1'b0;
    hold(1);
    expect_direct("R1 first", cap_first, '0);
    expect_direct("R1 held", {30'd0, cap_held}, '0);
    hold(2);

    // R2: latency, rising mode, pin change before E1, value present before E3
    tag = "R2";
    pin_is_input = 1'b1; cap_mode = 2'd1; hold(2);
    evt_pin = 1'b1;
    tick(); tick();
    lat_val = count_value;
    tick();
    expect_direct("R2 latency", cap_first, lat_val);
    hold(3);
    toggle(5); toggle(5);
    clear();
    cap_mode = 2'd2; toggle(5); toggle(5); clear();
    cap_mode = 2'd3; toggle(5); toggle(5); clear();

    // R3: pin as output
    tag = "R3";
    pin_is_input = 1'b0;
    for (int i = 0; i < 6; i++) toggle(4);
    pin_is_input = 1'b1; hold(4);

    // R4 / R6: fill in order, flag on first
    tag = "R4"; cap_on_second = 1'b0; clear();
    toggle(5);
    tag = "R6"; toggle(5);
    // R5: saturation
    tag = "R5";
    for (int i = 0; i < 5; i++) toggle(4);
    // R7: flag on second
    tag = "R7"; cap_on_second = 1'b1; clear();
    toggle(5); toggle(5); toggle(5);
    // R8: clear in every cycle of an edge window
    tag = "R8";
    for (int k = 0; k < 5; k++) begin
      clear(); evt_pin = ~evt_pin;
      for (int j = 0; j < k; j++) tick();
      clear(); hold(4);
    end
    // R9: re-arming from mode off, incl. edge in activation cycle
    tag = "R9";
    for (int k = 0; k < 4; k++) begin
      toggle(4); toggle(4);
      cap_mode = 2'd0; hold(2);
      evt_pin = ~evt_pin;
      for (int j = 0; j < k; j++) tick();
      cap_mode = 2'd3; hold(5);
    end
    // R10: mode none
    tag = "R10"; clear(); cap_mode = 2'd0;
    for (int i = 0; i < 6; i++) toggle(3);

    // random phase
    tag = "R4";
    cap_mode = 2'd3;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 2) == 0) evt_pin = ~evt_pin;
      if ($urandom_range(0, 40) == 0) clr_status = 1'b1;
      if ($urandom_range(0, 150) == 0) cap_mode = 2'($urandom);
      if ($urandom_range(0, 200) == 0) pin_is_input = ~pin_is_input;
      if ($urandom_range(0, 100) == 0) cap_on_second = ~cap_on_second;
      @(negedge clk);
      compare();
      count_value = $urandom;
      clr_status = 1'b0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule